// File: doc/BRIEF.md
# Floating-Point Register File with Paired Double Access and Condition Flag

This block holds the floating-point operand state of a processor core. It has thirty-two 32-bit words, kept apart from the integer registers. Each access port chooses per access between two views. A single view addresses one word. A double view addresses an aligned even/odd pair and presents it as one 64-bit value. Two read ports serve the source operands of a floating-point instruction, and one write port takes the result. Reads are combinational, and a read that overlaps a write in the same cycle returns the data being written.

Alongside the words, the block keeps a one-bit condition flag. A compare unit outside the block produces a result bit with a valid strobe, and the flag takes that value at the clock edge. Branch logic asks whether to take a branch. It supplies a sense bit that selects branching on a set flag or on a clear flag, and it gets a take decision back. The arithmetic units and the branch target computation sit outside this block.

Top module: `fpr_file`

## Requirements
- R1: A single write (`wr_dbl_i`=0) stores `wr_data_i[31:0]` into word `wr_idx_i` and ignores `wr_data_i[63:32]`. A later single read of that index returns the word in bits [31:0] and zero in bits [63:32].
- R2: A double write (`wr_dbl_i`=1) to an even index n stores `wr_data_i[31:0]` in word n and `wr_data_i[63:32]` in word n+1. A double read of an even index n returns {word n+1, word n}.
- R3: The single and double views alias the same storage. After a double write to pair n, single reads of n and n+1 return the low and high halves.
- R4: A double access with an odd index is illegal. On a read, the port's illegal flag is 1 and its data is all zero. On a write, `wr_illegal_o` is 1 and no word changes. `wr_illegal_o` is 0 for every legal or idle write port.
- R5: A read of a word that is being written in the same cycle returns the new data. This holds per word, so a double read whose pair is only half written returns the new half and the stored half.
- R6: The two read ports are independent. Each returns its own index and view, whatever the other port is doing.
- R7: Reset (active-low `rst_ni`) clears all 32 words and the condition flag to 0.
- R8: The condition flag takes `cmp_result_i` at a clock edge where `cmp_valid_i` is 1, and holds its value at every other edge.
- R9: `br_take_o` equals the condition flag when `br_sense_i`=1 (branch when set). It equals the inverted flag when `br_sense_i`=0 (branch when clear). It uses the registered flag, not a compare arriving in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write request |
| wr_dbl_i | input | 1 | Write view: 1 = double pair, 0 = single word |
| wr_idx_i | input | 5 | Write word index |
| wr_data_i | input | 64 | Write data; only [31:0] used for single writes |
| wr_illegal_o | output | 1 | Write request was a double with odd index (suppressed) |
| ra_idx_i | input | 5 | Read port A index |
| ra_dbl_i | input | 1 | Read port A view |
| ra_data_o | output | 64 | Read port A data |
| ra_illegal_o | output | 1 | Read port A odd-index double access |
| rb_idx_i | input | 5 | Read port B index |
| rb_dbl_i | input | 1 | Read port B view |
| rb_data_o | output | 64 | Read port B data |
| rb_illegal_o | output | 1 | Read port B odd-index double access |
| cmp_valid_i | input | 1 | Compare result strobe |
| cmp_result_i | input | 1 | Compare outcome to load into the flag |
| br_sense_i | input | 1 | Branch sense: 1 = branch when flag set, 0 = when clear |
| cond_o | output | 1 | Current condition flag |
| br_take_o | output | 1 | Branch decision from flag and sense |

## Verification
Read data, read illegal flags, `wr_illegal_o` and `br_take_o` are combinational, so they are due in the same cycle as their inputs. This includes the forwarded value of a write in flight. A write reaches storage at the next edge and shows from the following cycle on. The condition flag likewise shows a compare one edge after its strobe. The bench drives every input on the falling edge and samples one nanosecond later. Each check is matched to that timing: same-cycle checks compare against the data being written, and stored values and the flag are compared against a model that is updated only after the edge that commits them.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

    // Selects which flag polarity triggers a branch.
    typedef enum logic {
        BR_WHEN_CLEAR = 1'b0,
        BR_WHEN_SET   = 1'b1
    } br_sense_e;

    // Registered state of the condition unit.
    typedef struct packed {
        logic flag;
    } cc_state_t;

    // A double access needs an even index.
    function automatic logic pair_misaligned(input logic dbl, input logic idx_lsb);
        return dbl & idx_lsb;
    endfunction

endpackage

// File: rtl/fpr_wr_decode.sv
module fpr_wr_decode #(
    parameter int NUM_REGS = 32,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic                wr_en_i,
    input  logic                wr_dbl_i,
    input  logic [ADDR_W-1:0]   wr_idx_i,
    output logic [NUM_REGS-1:0] we_o,
    output logic [NUM_REGS-1:0] hi_sel_o,
    output logic                illegal_o
);
    logic wr_ok;

    assign illegal_o = wr_en_i & fpr_pkg::pair_misaligned(wr_dbl_i, wr_idx_i[0]);
    assign wr_ok     = wr_en_i & ~illegal_o;

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_dec
        localparam logic [ADDR_W-1:0] KIDX = ADDR_W'(k);
        // Double writes hit both words of the aligned pair; single writes one word.
        assign we_o[k]     = wr_ok & (wr_dbl_i ? (wr_idx_i[ADDR_W-1:1] == KIDX[ADDR_W-1:1])
                                               : (wr_idx_i == KIDX));
        // Odd word of a pair takes the upper half of the write bus.
        assign hi_sel_o[k] = wr_dbl_i & KIDX[0];
    end
endmodule

// File: rtl/fpr_bank.sv
module fpr_bank #(
    parameter int NUM_REGS = 32,
    parameter int WORD_W   = 32,
    localparam int DW      = 2 * WORD_W
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic [NUM_REGS-1:0]              we_i,
    input  logic [NUM_REGS-1:0]              hi_sel_i,
    input  logic [DW-1:0]                    wr_data_i,
    output logic [NUM_REGS-1:0][WORD_W-1:0]  regs_o
);
    typedef struct packed {
        logic [NUM_REGS-1:0][WORD_W-1:0] words;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (we_i[k]) begin
                st_d.words[k] = hi_sel_i[k] ? wr_data_i[DW-1:WORD_W] : wr_data_i[WORD_W-1:0];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs_o = st_q.words;
endmodule

// File: rtl/fpr_rd_port.sv
module fpr_rd_port #(
    parameter int NUM_REGS = 32,
    parameter int WORD_W   = 32,
    localparam int ADDR_W  = $clog2(NUM_REGS),
    localparam int DW      = 2 * WORD_W
) (
    input  logic [ADDR_W-1:0]               idx_i,
    input  logic                            dbl_i,
    input  logic [NUM_REGS-1:0][WORD_W-1:0] regs_i,
    input  logic [NUM_REGS-1:0]             we_i,
    input  logic [NUM_REGS-1:0]             hi_sel_i,
    input  logic [DW-1:0]                   wr_data_i,
    output logic [DW-1:0]                   data_o,
    output logic                            illegal_o
);
    // Per-word view with the write in flight already applied.
    logic [NUM_REGS-1:0][WORD_W-1:0] live;
    logic [ADDR_W-1:0]               odd_idx;

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_fwd
        assign live[k] = we_i[k] ? (hi_sel_i[k] ? wr_data_i[DW-1:WORD_W] : wr_data_i[WORD_W-1:0])
                                 : regs_i[k];
    end

    assign odd_idx = {idx_i[ADDR_W-1:1], 1'b1};

    always_comb begin
        illegal_o = fpr_pkg::pair_misaligned(dbl_i, idx_i[0]);
        if (illegal_o) begin
            data_o = '0;
        end else if (dbl_i) begin
            data_o = {live[odd_idx], live[idx_i]};
        end else begin
            data_o = {{WORD_W{1'b0}}, live[idx_i]};
        end
    end
endmodule

// File: rtl/fpr_cc.sv
module fpr_cc (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cmp_valid_i,
    input  logic cmp_result_i,
    input  logic br_sense_i,
    output logic cond_o,
    output logic br_take_o
);
    import fpr_pkg::*;

    cc_state_t cc_d, cc_q;
    br_sense_e sense;

    always_comb begin
        cc_d = cc_q;
        if (cmp_valid_i) begin
            cc_d.flag = cmp_result_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cc_q <= '0;
        end else begin
            cc_q <= cc_d;
        end
    end

    assign sense     = br_sense_e'(br_sense_i);
    assign cond_o    = cc_q.flag;
    assign br_take_o = (sense == BR_WHEN_SET) ? cc_q.flag : ~cc_q.flag;
endmodule

// File: rtl/fpr_file.sv
module fpr_file #(
    parameter int NUM_REGS = 32,
    parameter int WORD_W   = 32
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          wr_en_i,
    input  logic                          wr_dbl_i,
    input  logic [$clog2(NUM_REGS)-1:0]   wr_idx_i,
    input  logic [2*WORD_W-1:0]           wr_data_i,
    output logic                          wr_illegal_o,
    input  logic [$clog2(NUM_REGS)-1:0]   ra_idx_i,
    input  logic                          ra_dbl_i,
    output logic [2*WORD_W-1:0]           ra_data_o,
    output logic                          ra_illegal_o,
    input  logic [$clog2(NUM_REGS)-1:0]   rb_idx_i,
    input  logic                          rb_dbl_i,
    output logic [2*WORD_W-1:0]           rb_data_o,
    output logic                          rb_illegal_o,
    input  logic                          cmp_valid_i,
    input  logic                          cmp_result_i,
    input  logic                          br_sense_i,
    output logic                          cond_o,
    output logic                          br_take_o
);
    localparam int ADDR_W = $clog2(NUM_REGS);
    localparam int DW     = 2 * WORD_W;
    localparam int N_RD   = 2;

    logic [NUM_REGS-1:0]              wr_we;
    logic [NUM_REGS-1:0]              wr_hi;
    logic [NUM_REGS-1:0][WORD_W-1:0]  bank_regs;

    logic [N_RD-1:0][ADDR_W-1:0]      rd_idx;
    logic [N_RD-1:0]                  rd_dbl;
    logic [N_RD-1:0][DW-1:0]          rd_data;
    logic [N_RD-1:0]                  rd_illegal;

    fpr_wr_decode #(.NUM_REGS(NUM_REGS)) wr_dec_i (
        .wr_en_i   (wr_en_i),
        .wr_dbl_i  (wr_dbl_i),
        .wr_idx_i  (wr_idx_i),
        .we_o      (wr_we),
        .hi_sel_o  (wr_hi),
        .illegal_o (wr_illegal_o)
    );

    fpr_bank #(.NUM_REGS(NUM_REGS), .WORD_W(WORD_W)) bank_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .we_i      (wr_we),
        .hi_sel_i  (wr_hi),
        .wr_data_i (wr_data_i),
        .regs_o    (bank_regs)
    );

    assign rd_idx = {rb_idx_i, ra_idx_i};
    assign rd_dbl = {rb_dbl_i, ra_dbl_i};

    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        fpr_rd_port #(.NUM_REGS(NUM_REGS), .WORD_W(WORD_W)) port_i (
            .idx_i     (rd_idx[p]),
            .dbl_i     (rd_dbl[p]),
            .regs_i    (bank_regs),
            .we_i      (wr_we),
            .hi_sel_i  (wr_hi),
            .wr_data_i (wr_data_i),
            .data_o    (rd_data[p]),
            .illegal_o (rd_illegal[p])
        );
    end

    assign ra_data_o    = rd_data[0];
    assign rb_data_o    = rd_data[1];
    assign ra_illegal_o = rd_illegal[0];
    assign rb_illegal_o = rd_illegal[1];

    fpr_cc cc_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .cmp_valid_i  (cmp_valid_i),
        .cmp_result_i (cmp_result_i),
        .br_sense_i   (br_sense_i),
        .cond_o       (cond_o),
        .br_take_o    (br_take_o)
    );
endmodule

// File: rtl/fpr_file_chk.sv
module fpr_file_chk #(
    parameter int NUM_REGS = 32,
    parameter int WORD_W   = 32
) (
    input logic                            clk_i,
    input logic                            rst_ni,
    input logic                            wr_en_i,
    input logic                            wr_dbl_i,
    input logic [$clog2(NUM_REGS)-1:0]     wr_idx_i,
    input logic [2*WORD_W-1:0]             wr_data_i,
    input logic                            wr_illegal_o,
    input logic [$clog2(NUM_REGS)-1:0]     ra_idx_i,
    input logic                            ra_dbl_i,
    input logic [2*WORD_W-1:0]             ra_data_o,
    input logic                            ra_illegal_o,
    input logic                            cmp_valid_i,
    input logic                            cmp_result_i,
    input logic                            cond_o,
    input logic [NUM_REGS-1:0][WORD_W-1:0] bank_regs
);
    localparam int DW = 2 * WORD_W;

    // R1
    single_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i && !wr_dbl_i |=> bank_regs[$past(wr_idx_i)] == $past(wr_data_i[WORD_W-1:0]));

    // R1
    single_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ra_dbl_i |-> ra_data_o[DW-1:WORD_W] == '0);

    // R4
    odd_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ra_dbl_i && ra_idx_i[0] |-> ra_illegal_o && ra_data_o == '0);

    // R4
    odd_write_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_illegal_o |=> $stable(bank_regs));

    // R5
    single_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i && !wr_dbl_i && !ra_dbl_i && ra_idx_i == wr_idx_i
        |-> ra_data_o[WORD_W-1:0] == wr_data_i[WORD_W-1:0]);

    // R8
    flag_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmp_valid_i |=> cond_o == $past(cmp_result_i));

    // R8
    flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cmp_valid_i |=> $stable(cond_o));
endmodule

bind fpr_file fpr_file_chk #(.NUM_REGS(NUM_REGS), .WORD_W(WORD_W)) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_dbl_i     (wr_dbl_i),
    .wr_idx_i     (wr_idx_i),
    .wr_data_i    (wr_data_i),
    .wr_illegal_o (wr_illegal_o),
    .ra_idx_i     (ra_idx_i),
    .ra_dbl_i     (ra_dbl_i),
    .ra_data_o    (ra_data_o),
    .ra_illegal_o (ra_illegal_o),
    .cmp_valid_i  (cmp_valid_i),
    .cmp_result_i (cmp_result_i),
    .cond_o       (cond_o),
    .bank_regs    (bank_regs)
);

// File: tb/fpr_file_tb_top.sv
`timescale 1ns/1ps
module fpr_file_tb_top;
    localparam int NR = 32;

    logic        clk_i = 1'b0;
    logic        rst_ni;
    logic        wr_en_i, wr_dbl_i;
    logic [4:0]  wr_idx_i;
    logic [63:0] wr_data_i;
    logic        wr_illegal_o;
    logic [4:0]  ra_idx_i, rb_idx_i;
    logic        ra_dbl_i, rb_dbl_i;
    logic [63:0] ra_data_o, rb_data_o;
    logic        ra_illegal_o, rb_illegal_o;
    logic        cmp_valid_i, cmp_result_i, br_sense_i;
    logic        cond_o, br_take_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic [31:0] mdl [NR];
    logic        cond_mdl;

    always #2.5 clk_i = ~clk_i;

    fpr_file dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .wr_en_i(wr_en_i), .wr_dbl_i(wr_dbl_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
        .wr_illegal_o(wr_illegal_o),
        .ra_idx_i(ra_idx_i), .ra_dbl_i(ra_dbl_i), .ra_data_o(ra_data_o), .ra_illegal_o(ra_illegal_o),
        .rb_idx_i(rb_idx_i), .rb_dbl_i(rb_dbl_i), .rb_data_o(rb_data_o), .rb_illegal_o(rb_illegal_o),
        .cmp_valid_i(cmp_valid_i), .cmp_result_i(cmp_result_i), .br_sense_i(br_sense_i),
        .cond_o(cond_o), .br_take_o(br_take_o)
    );

    function automatic logic [31:0] pat(input int k);
        return (32'h9E3779B9 * 32'(k + 1)) ^ 32'h00A5_0000;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en_i = 0; wr_dbl_i = 0; wr_idx_i = 0; wr_data_i = '0;
        ra_idx_i = 0; ra_dbl_i = 0; rb_idx_i = 0; rb_dbl_i = 0;
        cmp_valid_i = 0; cmp_result_i = 0; br_sense_i = 0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        repeat (100000) @(posedge clk_i);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        idle();
        rst_ni = 0;
        cond_mdl = 0;
        for (int k = 0; k < NR; k++) mdl[k] = '0;
        repeat (4) @(posedge clk_i);
        @(negedge clk_i); rst_ni = 1;

        // R7: reset contents on both ports, flag clear
        for (int k = 0; k < NR; k++) begin
            @(negedge clk_i); idle();
            ra_idx_i = 5'(k); rb_idx_i = 5'(NR - 1 - k);
            #1;
            chk("R7 port A reset word", ra_data_o, 64'h0);
            chk("R7 port B reset word", rb_data_o, 64'h0);
        end
        chk("R7 flag reset", {63'h0, cond_o}, 64'h0);
        chk("R9 branch-when-clear after reset", {63'h0, br_take_o}, 64'h1);

        // R1/R5/R6: single writes, forwarding on A, neighbour on B
        for (int k = 0; k < NR; k++) begin
            @(negedge clk_i); idle();
            wr_en_i = 1; wr_idx_i = 5'(k); wr_data_i = {~pat(k), pat(k)};
            ra_idx_i = 5'(k); rb_idx_i = 5'(k ^ 1);
            #1;
            chk("R5 single forward", ra_data_o, {32'h0, pat(k)});
            chk("R6 port B neighbour", rb_data_o, {32'h0, mdl[k ^ 1]});
            chk("R4 legal write flag", {63'h0, wr_illegal_o}, 64'h0);
            mdl[k] = pat(k);
        end
        for (int k = 0; k < NR; k++) begin
            @(negedge clk_i); idle();
            ra_idx_i = 5'(k); rb_idx_i = 5'(k & 30); rb_dbl_i = 1;
            #1;
            chk("R1 single readback", ra_data_o, {32'h0, mdl[k]});
            chk("R2 double read of singles", rb_data_o, {mdl[(k & 30) + 1], mdl[k & 30]});
        end

        // R2/R5: double writes to every even pair
        for (int n = 0; n < NR; n += 2) begin
            @(negedge clk_i); idle();
            wr_en_i = 1; wr_dbl_i = 1; wr_idx_i = 5'(n);
            wr_data_i = {pat(n + 80), pat(n + 40)};
            rb_idx_i = 5'(n); rb_dbl_i = 1; ra_idx_i = 5'(n + 1);
            #1;
            chk("R5 double forward", rb_data_o, {pat(n + 80), pat(n + 40)});
            chk("R5 single view of double write", ra_data_o, {32'h0, pat(n + 80)});
            chk("R4 legal double flag", {63'h0, wr_illegal_o}, 64'h0);
            mdl[n] = pat(n + 40); mdl[n + 1] = pat(n + 80);
        end
        for (int k = 0; k < NR; k++) begin
            @(negedge clk_i); idle();
            ra_idx_i = 5'(k); rb_idx_i = 5'(k & 30); rb_dbl_i = 1;
            #1;
            chk("R3 single alias of pair", ra_data_o, {32'h0, mdl[k]});
            chk("R2 double readback", rb_data_o, {mdl[(k & 30) + 1], mdl[k & 30]});
        end

        // R4: odd double writes are flagged and suppressed
        for (int n = 1; n < NR; n += 2) begin
            @(negedge clk_i); idle();
            wr_en_i = 1; wr_dbl_i = 1; wr_idx_i = 5'(n); wr_data_i = 64'hDEAD_BEEF_0BAD_F00D;
            ra_idx_i = 5'(n - 1); ra_dbl_i = 1;
            #1;
            chk("R4 odd write flag", {63'h0, wr_illegal_o}, 64'h1);
            chk("R4 no forward of odd write", ra_data_o, {mdl[n], mdl[n - 1]});
            @(negedge clk_i); idle();
            rb_idx_i = 5'(n - 1); rb_dbl_i = 1;
            #1;
            chk("R4 pair unchanged after odd write", rb_data_o, {mdl[n], mdl[n - 1]});
        end
        @(negedge clk_i); idle();
        wr_dbl_i = 1; wr_idx_i = 5'd3;
        #1;
        chk("R4 idle port no flag", {63'h0, wr_illegal_o}, 64'h0);

        // R4: odd double reads on both ports
        for (int n = 1; n < NR; n += 2) begin
            @(negedge clk_i); idle();
            ra_idx_i = 5'(n); ra_dbl_i = 1; rb_idx_i = 5'(NR - n); rb_dbl_i = 1;
            #1;
            chk("R4 port A odd read", {ra_illegal_o, ra_data_o[62:0]}, {1'b1, 63'h0});
            chk("R4 port B odd read", {rb_illegal_o, rb_data_o[62:0]}, {1'b1, 63'h0});
        end

        // R5: half of a pair written while read as a double
        for (int n = 0; n < NR; n += 2) begin
            @(negedge clk_i); idle();
            wr_en_i = 1; wr_idx_i = 5'(n + (n >> 1) % 2); wr_data_i = {32'hFFFF_FFFF, pat(n + 7)};
            ra_idx_i = 5'(n); ra_dbl_i = 1;
            #1;
            if ((n >> 1) % 2 == 1) begin
                chk("R5 partial forward high", ra_data_o, {pat(n + 7), mdl[n]});
                mdl[n + 1] = pat(n + 7);
            end else begin
                chk("R5 partial forward low", ra_data_o, {mdl[n + 1], pat(n + 7)});
                mdl[n] = pat(n + 7);
            end
        end

        // R8/R9: flag update timing and branch sense
        for (int s = 0; s < 24; s++) begin
            @(negedge clk_i); idle();
            cmp_valid_i  = (s % 3 != 2);
            cmp_result_i = s[0] ^ s[2];
            br_sense_i   = s[1];
            #1;
            chk("R8 flag value", {63'h0, cond_o}, {63'h0, cond_mdl});
            chk("R9 branch decision", {63'h0, br_take_o},
                {63'h0, (s[1] ? cond_mdl : ~cond_mdl)});
            if (cmp_valid_i) cond_mdl = cmp_result_i;
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule